// File: doc/BRIEF.md
# Protected Sector-Write Flash Controller

This block is the write-control core of a word-wide (16-bit) flash memory. It sits behind an asynchronous memory-style bus. The bus has an active-low chip select, read strobe and write strobe, an address, and a data path split into an input half and an output half with an output-enable flag. A fast system clock samples the bus through a synchronizer. Every write strobe is filtered by its width before it counts.

No data can be written until a fixed three-word unlock sequence has been seen. After the unlock, up to one full sector of 128 words is gathered into a page buffer, in any order. Each new word must start within an inactivity window. When the window lapses, the controller runs a timed erase-and-program of the whole sector: loaded words take their new values and every other word of the sector becomes FFFFh. While the timer runs, reads return a polling word instead of array data. In that word two bits are inverted copies of the last written data and two bits change on every read.

The state machine has seven states:
- ST_LOCKED: idle and write-protected.
- ST_CMD1 and ST_CMD2: first and second unlock word seen.
- ST_OPEN: unlocked, waiting for the first data word.
- ST_LOAD: gathering words of one sector.
- ST_PROGRAM: timed erase-and-program.
- ST_DUMMY: timed busy period with no data change.

Transitions:
- ST_LOCKED goes to ST_CMD1 on the first unlock word. Any other write sends it to ST_DUMMY.
- ST_CMD1 goes to ST_CMD2 on the second unlock word. ST_CMD2 goes to ST_OPEN on the third. A wrong word in either state goes to ST_DUMMY, and a lapsed window returns to ST_LOCKED.
- ST_OPEN goes to ST_LOAD on any write. A lapsed window returns it to ST_LOCKED.
- ST_LOAD stays in ST_LOAD on a write to the same sector. A write to another sector aborts to ST_LOCKED. A lapsed window goes to ST_PROGRAM.
- ST_PROGRAM and ST_DUMMY both return to ST_LOCKED when the program timer ends.

Top module: `sector_flash_ctl`

## Requirements
- R1: After reset the block is in ST_LOCKED and `dq_oe` is low while no read is under way.
- R2: Writing is possible only after three accepted writes, in this order: address 155h with data 00AAh, then address 0AAh with data 0055h, then address 155h with data 00A0h. Each program operation needs a fresh sequence.
- R3: Address bits [ADDR_W-1:7] select the sector and bits [6:0] select the word. Words of a sector may be loaded in any order, and each reads back its loaded value after programming.
- R4: After programming, every word of the sector that was not loaded reads FFFFh.
- R5: A write strobe that starts within LOAD_CYC cycles after the end of the previous accepted strobe joins the same page. When the window lapses with no new strobe, ST_LOAD enters ST_PROGRAM. A strobe that starts in the last cycle of the window wins.
- R6: ST_PROGRAM and ST_DUMMY last PROG_CYC cycles. During them a read at any address returns the last accepted write data with bits 15 and 7 inverted.
- R7: While busy, bits 14 and 6 of the read word are both 0 on the first read after busy starts. They invert after each read ends.
- R8: An accepted write in ST_LOCKED that is not the first unlock word changes no stored data. It still starts a PROG_CYC busy period with polling reads.
- R9: A write strobe shorter than MIN_PULSE synchronized cycles is ignored. So is a strobe made while the read strobe `oe_n` is low.
- R10: In ST_LOAD, an accepted write to a different sector aborts the page. The block returns to ST_LOCKED without programming, and reads at once return the old array data.
- R11: Write strobes during ST_PROGRAM or ST_DUMMY are ignored.
- R12: A write's address is taken when the strobe begins (the later of `ce_n` and `we_n` falling). Its data is taken when the strobe ends (the first of the two rising).
- R13: `dq_oe` is high only when `ce_n` and `oe_n` are low and `we_n` is high, after the synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low read strobe |
| we_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Word address; upper bits are the sector, low 7 bits the word |
| dq_i | input | 16 | Write data from the bus |
| dq_o | output | 16 | Read data or polling word |
| dq_oe | output | 1 | High while the block drives the data bus |

## Verification
Two events can land in the same cycle: the lapse of the load window and the start of the next write strobe. The design gives the strobe priority. The bench places one strobe a few cycles inside the window and a later one well outside it. It then reads the sector back. The first word must appear in the programmed sector, and the late word must be absent because it arrived during ST_PROGRAM.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;

    localparam int WORD_W = 16;
    localparam int LANE_W = 8;

    typedef enum logic [2:0] {
        ST_LOCKED,
        ST_CMD1,
        ST_CMD2,
        ST_OPEN,
        ST_LOAD,
        ST_PROGRAM,
        ST_DUMMY
    } sfc_state_e;

    // In each byte lane, invert the top bit and replace the next bit with the toggle.
    function automatic logic [WORD_W-1:0] poll_word(input logic [WORD_W-1:0] d,
                                                    input logic t);
        logic [WORD_W-1:0] r;
        r = d;
        for (int k = 0; k < WORD_W / LANE_W; k++) begin
            r[k*LANE_W + LANE_W - 1] = ~d[k*LANE_W + LANE_W - 1];
            r[k*LANE_W + LANE_W - 2] = t;
        end
        return r;
    endfunction

endpackage

// File: rtl/sfc_bus_sync.sv
`timescale 1ns/1ps
module sfc_bus_sync
    import sfc_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PULSE   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] dq_i,
    output logic              wr_busy,
    output logic              wr_accept,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              rd_act,
    output logic              rd_end,
    output logic [ADDR_W-1:0] addr_s
);

    localparam int PACK_W = 3 + ADDR_W + WORD_W;
    localparam int WID_W  = $clog2(MIN_PULSE + 1);
    localparam logic [PACK_W-1:0] RST_VAL = {3'b111, {(PACK_W-3){1'b0}}};

    logic [PACK_W-1:0] pipe [SYNC_STAGES];
    logic [PACK_W-1:0] tail;
    logic              ce_s, oe_s, we_s;
    logic [WORD_W-1:0] dq_s;
    logic              wr_now, wr_prev, rd_prev;
    logic [WID_W-1:0]  width;

    // Control, address and data all pass through the same number of stages.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= {ce_n, oe_n, we_n, addr, dq_i};
            for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign tail   = pipe[SYNC_STAGES-1];
    assign ce_s   = tail[PACK_W-1];
    assign oe_s   = tail[PACK_W-2];
    assign we_s   = tail[PACK_W-3];
    assign addr_s = tail[ADDR_W+WORD_W-1:WORD_W];
    assign dq_s   = tail[WORD_W-1:0];

    // A write needs both selects low with the read strobe high.
    assign wr_now  = !ce_s && !we_s && oe_s;
    assign rd_act  = !ce_s && !oe_s && we_s;
    assign wr_busy = wr_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_prev   <= 1'b0;
            rd_prev   <= 1'b0;
            width     <= '0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_accept <= 1'b0;
            rd_end    <= 1'b0;
        end else begin
            wr_prev <= wr_now;
            rd_prev <= rd_act;
            rd_end  <= !rd_act && rd_prev;
            if (wr_now && !wr_prev) begin
                wr_addr <= addr_s;
                width   <= WID_W'(1);
            end else if (wr_now && int'(width) < MIN_PULSE) begin
                width <= width + 1'b1;
            end
            if (!wr_now && wr_prev) begin
                wr_data <= dq_s;
            end
            wr_accept <= !wr_now && wr_prev && (int'(width) >= MIN_PULSE);
        end
    end

    // R12
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && wr_prev) |=> $stable(wr_addr));

    // R9
    width_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> (int'($past(width)) >= MIN_PULSE));

endmodule

// File: rtl/sfc_page_buf.sv
`timescale 1ns/1ps
module sfc_page_buf
    import sfc_pkg::*;
#(
    parameter int WORD_BITS = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [WORD_BITS-1:0] wr_idx,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic [WORD_BITS-1:0] rd_idx,
    output logic [WORD_W-1:0]    rd_word
);

    localparam int WORDS = 1 << WORD_BITS;

    logic [WORD_W-1:0] mem [WORDS];
    logic [WORDS-1:0]  valid;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= '0;
        end else if (clr) begin
            valid <= '0;
        end else if (wr_en) begin
            valid[wr_idx] <= 1'b1;
        end
    end

    // Words never loaded come out as the erased value.
    assign rd_word = valid[rd_idx] ? mem[rd_idx] : '1;

    // R4
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ($countones(valid) == 0));

endmodule

// File: rtl/sfc_array.sv
`timescale 1ns/1ps
module sfc_array
    import sfc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/sector_flash_ctl.sv
`timescale 1ns/1ps
module sector_flash_ctl
    import sfc_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int WORD_BITS   = 7,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PULSE   = 3,
    parameter int LOAD_CYC    = 30000,
    parameter int PROG_CYC    = 4000000,
    parameter int UNL_A1      = 'h155,
    parameter int UNL_D1      = 'h00AA,
    parameter int UNL_A2      = 'h0AA,
    parameter int UNL_D2      = 'h0055,
    parameter int UNL_A3      = 'h155,
    parameter int UNL_D3      = 'h00A0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] dq_i,
    output logic [WORD_W-1:0] dq_o,
    output logic              dq_oe
);

    localparam int SEC_W  = ADDR_W - WORD_BITS;
    localparam int WORDS  = 1 << WORD_BITS;
    localparam int LCNT_W = $clog2(LOAD_CYC + 1);
    localparam int PCNT_R = $clog2(PROG_CYC + 1);
    localparam int PCNT_W = (PCNT_R > WORD_BITS + 1) ? PCNT_R : WORD_BITS + 1;
    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(UNL_A1);
    localparam logic [ADDR_W-1:0] A2 = ADDR_W'(UNL_A2);
    localparam logic [ADDR_W-1:0] A3 = ADDR_W'(UNL_A3);
    localparam logic [WORD_W-1:0] D1 = WORD_W'(UNL_D1);
    localparam logic [WORD_W-1:0] D2 = WORD_W'(UNL_D2);
    localparam logic [WORD_W-1:0] D3 = WORD_W'(UNL_D3);

    sfc_state_e        state, state_nx;
    logic              wr_busy, wr_accept, rd_act, rd_end;
    logic [ADDR_W-1:0] wr_addr, addr_s;
    logic [WORD_W-1:0] wr_data, buf_word, ram_q;
    logic [SEC_W-1:0]  sector_q, wr_sec;
    logic [WORD_BITS-1:0] wr_idx;
    logic [LCNT_W-1:0] idle_cnt;
    logic [PCNT_W-1:0] prog_cnt;
    logic [WORD_W-1:0] last_data;
    logic              tog;
    logic              hit1, hit2, hit3, same_sec;
    logic              timeout, prog_done, busy, busy_nx;
    logic              buf_clr, buf_we, ram_we;

    sfc_bus_sync #(
        .ADDR_W      (ADDR_W),
        .SYNC_STAGES (SYNC_STAGES),
        .MIN_PULSE   (MIN_PULSE)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .addr      (addr),
        .dq_i      (dq_i),
        .wr_busy   (wr_busy),
        .wr_accept (wr_accept),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_act    (rd_act),
        .rd_end    (rd_end),
        .addr_s    (addr_s)
    );

    assign wr_sec    = wr_addr[ADDR_W-1:WORD_BITS];
    assign wr_idx    = wr_addr[WORD_BITS-1:0];
    assign hit1      = (wr_addr == A1) && (wr_data == D1);
    assign hit2      = (wr_addr == A2) && (wr_data == D2);
    assign hit3      = (wr_addr == A3) && (wr_data == D3);
    assign same_sec  = (wr_sec == sector_q);
    // A strobe under way holds the window open, so a strobe wins a tie with expiry.
    assign timeout   = !wr_busy && (int'(idle_cnt) == LOAD_CYC - 1);
    assign prog_done = (int'(prog_cnt) == PROG_CYC - 1);
    assign busy      = (state == ST_PROGRAM) || (state == ST_DUMMY);
    assign busy_nx   = (state_nx == ST_PROGRAM) || (state_nx == ST_DUMMY);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOCKED: begin
                if (wr_accept) state_nx = hit1 ? ST_CMD1 : ST_DUMMY;
            end
            ST_CMD1: begin
                if (wr_accept)    state_nx = hit2 ? ST_CMD2 : ST_DUMMY;
                else if (timeout) state_nx = ST_LOCKED;
            end
            ST_CMD2: begin
                if (wr_accept)    state_nx = hit3 ? ST_OPEN : ST_DUMMY;
                else if (timeout) state_nx = ST_LOCKED;
            end
            ST_OPEN: begin
                if (wr_accept)    state_nx = ST_LOAD;
                else if (timeout) state_nx = ST_LOCKED;
            end
            ST_LOAD: begin
                if (wr_accept)    state_nx = same_sec ? ST_LOAD : ST_LOCKED;
                else if (timeout) state_nx = ST_PROGRAM;
            end
            ST_PROGRAM: begin
                if (prog_done) state_nx = ST_LOCKED;
            end
            ST_DUMMY: begin
                if (prog_done) state_nx = ST_LOCKED;
            end
            default: state_nx = ST_LOCKED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= state_nx;
    end

    // Counters, sector tag, polling data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt  <= '0;
            prog_cnt  <= '0;
            sector_q  <= '0;
            last_data <= '0;
            tog       <= 1'b0;
        end else begin
            if (state_nx != state || wr_busy || wr_accept) begin
                idle_cnt <= '0;
            end else if (int'(idle_cnt) < LOAD_CYC - 1) begin
                idle_cnt <= idle_cnt + 1'b1;
            end
            if (state_nx != state) begin
                prog_cnt <= '0;
            end else if (busy) begin
                prog_cnt <= prog_cnt + 1'b1;
            end
            if (state == ST_OPEN && wr_accept) begin
                sector_q <= wr_sec;
            end
            if (wr_accept && !busy) begin
                last_data <= wr_data;
            end
            if (busy_nx && !busy) begin
                tog <= 1'b0;
            end else if (busy && rd_end) begin
                tog <= ~tog;
            end
        end
    end

    // Page buffer and array control
    assign buf_clr = (state == ST_CMD2) && wr_accept && hit3;
    assign buf_we  = wr_accept && ((state == ST_OPEN) || (state == ST_LOAD && same_sec));
    assign ram_we  = (state == ST_PROGRAM) && (int'(prog_cnt) < WORDS);

    sfc_page_buf #(
        .WORD_BITS (WORD_BITS)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (buf_we),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (prog_cnt[WORD_BITS-1:0]),
        .rd_word (buf_word)
    );

    sfc_array #(
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk   (clk),
        .we    (ram_we),
        .waddr ({sector_q, prog_cnt[WORD_BITS-1:0]}),
        .wdata (buf_word),
        .raddr (addr_s),
        .rdata (ram_q)
    );

    // Read data path
    always_comb begin
        dq_oe = rd_act;
        if (!rd_act)   dq_o = '0;
        else if (busy) dq_o = poll_word(last_data, tog);
        else           dq_o = ram_q;
    end

    // R2
    open_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && $past(state) != ST_OPEN) |-> ($past(state) == ST_CMD2));

    // R5
    prog_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROGRAM && $past(state) != ST_PROGRAM) |-> ($past(state) == ST_LOAD));

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && wr_accept && wr_sec != sector_q) |=> (state == ST_LOCKED));

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROGRAM && wr_accept && !prog_done) |=> (state == ST_PROGRAM && $stable(sector_q)));

    // R7
    tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_end && state_nx == state) |=> (tog != $past(tog)));

    // R6
    poll_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && busy) |-> (dq_o[15] != last_data[15] && dq_o[7] != last_data[7]));

    // R4
    commit_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && $past(ram_we)) |-> $stable(sector_q));

endmodule

// File: tb/sector_flash_ctl_tb.sv
`timescale 1ns/1ps
module sector_flash_ctl_tb;

    localparam int AW = 10;
    localparam int L  = 40;
    localparam int P  = 300;

    localparam logic [31:0] VEC [7] = '{
        32'h017F_A5A5, 32'h0100_0001, 32'h0140_8080, 32'h0133_C3C3,
        32'h0101_7E7E, 32'h0155_1248, 32'h017E_0F0F
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n, oe_n, we_n;
    logic [AW-1:0] addr;
    logic [15:0]   dq_i;
    logic [15:0]   dq_o;
    logic          dq_oe;
    int            n_chk = 0;
    int            n_fail = 0;

    always #2.5 clk = ~clk;

    sector_flash_ctl #(
        .ADDR_W (AW), .WORD_BITS (7), .SYNC_STAGES (2), .MIN_PULSE (3),
        .LOAD_CYC (L), .PROG_CYC (P)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n),
        .addr (addr), .dq_i (dq_i), .dq_o (dq_o), .dq_oe (dq_oe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_poll(input logic [15:0] d, input logic t);
        return {~d[15], t, d[13:8], ~d[7], t, d[5:0]};
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input int width);
        @(negedge clk);
        addr = a; dq_i = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        cyc(width);
        we_n = 1'b1; ce_n = 1'b1;
        cyc(4);
    endtask

    task automatic unlock();
        wr(10'h155, 16'h00AA, 6);
        wr(10'h0AA, 16'h0055, 6);
        wr(10'h155, 16'h00A0, 6);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [15:0] q);
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        cyc(6);
        q = dq_o;
        check("R13 dq_oe during read", {15'd0, dq_oe}, 16'd1);
        oe_n = 1'b1; ce_n = 1'b1;
        cyc(3);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] q;
        logic [15:0] last;
        rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; dq_i = '0;
        cyc(5);
        rst_n = 1'b1;
        cyc(3);
        // R1: reset state, bus not driven
        check("R1 dq_oe after reset", {15'd0, dq_oe}, 16'd0);

        // R13: partial strobes do not drive the bus
        ce_n = 1'b0; cyc(5);
        check("R13 ce only", {15'd0, dq_oe}, 16'd0);
        ce_n = 1'b1; oe_n = 1'b0; cyc(5);
        check("R13 oe only", {15'd0, dq_oe}, 16'd0);
        oe_n = 1'b1; cyc(5);

        // Table walk: R2 unlock, R3 scattered load into sector 2
        unlock();
        for (int i = 0; i < 7; i++) wr(VEC[i][16+AW-1:16], VEC[i][15:0], 6);
        last = VEC[6][15:0];
        cyc(L + 10);
        // R6, R7: polling words during ST_PROGRAM
        rd(10'h000, q); check("R6 R7 first poll", q, exp_poll(last, 1'b0));
        rd(10'h3FF, q); check("R6 R7 second poll", q, exp_poll(last, 1'b1));
        rd(10'h100, q); check("R7 third poll", q, exp_poll(last, 1'b0));
        cyc(P);
        for (int i = 0; i < 7; i++) begin
            rd(VEC[i][16+AW-1:16], q);
            check("R3 readback", q, VEC[i][15:0]);
        end
        // R4: unloaded words erased
        rd(10'h102, q); check("R4 unloaded 102", q, 16'hFFFF);
        rd(10'h17D, q); check("R4 unloaded 17D", q, 16'hFFFF);

        // R8 and R2: write without unlock gives a dummy busy period
        wr(10'h100, 16'hDEAD, 6);
        rd(10'h100, q); check("R8 dummy poll", q, exp_poll(16'hDEAD, 1'b0));
        cyc(P);
        rd(10'h100, q); check("R8 R2 data unchanged", q, 16'h0001);

        // R9, R12, R5, R11 in sector 3
        unlock();
        wr(10'h181, 16'h1111, 1);                  // R9 glitch
        @(negedge clk);                            // R9 write with oe_n low
        addr = 10'h182; dq_i = 16'h2222; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        cyc(6); we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1; cyc(4);
        @(negedge clk);                            // R12 split strobe
        addr = 10'h183; dq_i = 16'h2222; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        cyc(2); addr = 10'h1FF; dq_i = 16'h3333;
        cyc(4); we_n = 1'b1; ce_n = 1'b1; cyc(4);
        cyc(L - 14);
        wr(10'h190, 16'h4444, 6);                  // R5 inside window
        cyc(L + 8);
        wr(10'h191, 16'h5555, 6);                  // R11 during program
        cyc(P);
        rd(10'h181, q); check("R9 glitch ignored", q, 16'hFFFF);
        rd(10'h182, q); check("R9 oe low ignored", q, 16'hFFFF);
        rd(10'h183, q); check("R12 addr at start data at end", q, 16'h3333);
        rd(10'h1FF, q); check("R12 late address unused", q, 16'hFFFF);
        rd(10'h190, q); check("R5 word inside window", q, 16'h4444);
        rd(10'h191, q); check("R11 busy write ignored", q, 16'hFFFF);

        // R10: different sector aborts the page
        unlock();
        wr(10'h100, 16'hBEEF, 6);
        wr(10'h200, 16'h9999, 6);
        rd(10'h100, q); check("R10 abort true data", q, 16'h0001);
        cyc(L + P);
        rd(10'h100, q); check("R10 no program", q, 16'h0001);

        summary();
        $finish;
    end

endmodule